// File: doc/BRIEF.md
# Quad Double-Ranked Converter Input Registers

This block models the digital input side of a four-channel, 12-bit converter. Each channel has two register stages. The first stage is a holding register that takes a word from the parallel data port. The second stage is the output register, and it drives that channel's output word. Six active-low strobes come in: select, latch, mode, transfer, read and clear. A 2-bit channel address also comes in. Together they decide when a word lands in a holding register and when holding registers move to the output registers.

The strobes, data and address arrive asynchronously. Each passes through a two-flop synchronizer into the system clock domain. Edges of the select and latch strobes are detected after synchronization.

The order in which select and latch are released picks the mode of operation:
- Releasing select first gives a preload. Only the holding register is written.
- Releasing latch first makes the new word reach the outputs.
- A bare select pulse, with every other strobe inactive, copies all four holding registers to the outputs in the same cycle. The address plays no part in this.

The data port is a strobe-qualified parallel bus, not a valid/ready stream. The strobes act as the handshake, and there is no back-pressure. The sender must hold data and address stable while select and latch are both low, for at least three clock cycles.

Top module: `quad_dac_input_regs`

## Requirements
- R1: While the synchronized clear strobe is low, both stages of every channel are held at zero, whatever the other strobes do. A write attempted during clear is lost. The same holds after the system reset `rst_n`.
- R2: While select and latch are both low and mode is high, the data word is written into the holding register of the channel named by `addr`. No other channel's holding register changes.
- R3: If select returns high while latch is still low, no output word changes (preload).
- R4: If latch returns high while select is still low, all output registers take their holding register values, so the channel just written shows its new word.
- R5: A falling edge of select while latch, mode, transfer, read and clear are all high copies all four holding registers to the output registers in the same cycle, whatever the address.
- R6: Copying to the output registers never changes any holding register, so a second bare update leaves the outputs unchanged.
- R7: Several channels may be written during one long select-low period by toggling latch per address. After latch is released, every channel written shows its new word.
- R8: A series of preloads to different channels changes no output. A later bare update makes all of them appear in the same cycle.
- R9: A select pulse while read is low changes no output and no holding register.
- R10: A select pulse while mode or transfer is low changes no output.
- R11: An output word changes on the third rising clock edge after the strobe change that causes it. It is unchanged after the second edge.
- Output packing: `dout` carries channel k in bits [12k+11:12k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| din | input | 12 | Parallel data word |
| addr | input | 2 | Channel address for writes |
| sel_n | input | 1 | Active-low chip select |
| latch_n | input | 1 | Active-low latch select |
| mode_n | input | 1 | Active-low mode select; blocks writes and updates |
| xfer_n | input | 1 | Active-low transfer; blocks updates |
| read_n | input | 1 | Active-low read; blocks updates, alters nothing |
| clear_n | input | 1 | Active-low clear of both stages |
| dout | output | 48 | Four output register words, channel 0 in the low bits |

## Verification
A wrong holding register stays invisible until the next update. The bench therefore follows every preload with a bare update and compares all four words. A corrupted holding value then shows up at most three edges after that update. A spurious or missing copy changes `dout` at the third edge after the strobe edge that caused it. The bench samples that exact edge once, and samples one edge before it to pin down the latency. The bench also repeats a bare update to catch a copy that disturbs the holding stage.

// File: rtl/qdir_pkg.sv
package qdir_pkg;
  // bit positions inside the synchronized strobe vector (asserted = 1)
  localparam int STB_SEL   = 0;
  localparam int STB_LATCH = 1;
  localparam int STB_MODE  = 2;
  localparam int STB_XFER  = 3;
  localparam int STB_READ  = 4;
  localparam int STB_CLEAR = 5;
  localparam int NUM_STB   = 6;
endpackage

// File: rtl/qdir_strobe_sync.sv
module qdir_strobe_sync #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_n,
  output logic [N-1:0] act
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_bit
      logic meta_n, safe_n;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_n <= 1'b1;
          safe_n <= 1'b1;
        end else begin
          meta_n <= raw_n[g];
          safe_n <= meta_n;
        end
      end
      assign act[g] = ~safe_n;
    end
  endgenerate
endmodule

// File: rtl/qdir_ctrl.sv
module qdir_ctrl
  import qdir_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_STB-1:0] act,
  input  logic [ADDR_W-1:0]  addr_s,
  output logic [NUM_CH-1:0]  wr_vec,
  output logic               upd,
  output logic               clr
);
  logic sel_q, latch_q;
  logic sel_on, latch_off, quiet, wr_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      sel_q   <= act[STB_SEL];
      latch_q <= act[STB_LATCH];
    end
  end

  always_comb begin
    clr       = act[STB_CLEAR];
    sel_on    = act[STB_SEL] & ~sel_q;
    latch_off = ~act[STB_LATCH] & latch_q;
    quiet     = ~act[STB_MODE] & ~act[STB_XFER] & ~act[STB_READ];
    wr_go     = act[STB_SEL] & act[STB_LATCH] & ~act[STB_MODE] & ~clr;
    upd       = ~clr & quiet &
                ((latch_off & act[STB_SEL]) | (sel_on & ~act[STB_LATCH]));
  end

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_dec
      assign wr_vec[c] = wr_go & (addr_s == ADDR_W'(c));
    end
  endgenerate
endmodule

// File: rtl/qdir_ranks.sv
module qdir_ranks #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     upd,
  input  logic [NUM_CH-1:0]        wr_vec,
  input  logic [DATA_W-1:0]        wdata,
  output logic [NUM_CH*DATA_W-1:0] first_flat,
  output logic [NUM_CH*DATA_W-1:0] second_flat
);
  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      logic [DATA_W-1:0] hold_q, out_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hold_q <= '0;
          out_q  <= '0;
        end else if (clr) begin
          hold_q <= '0;
          out_q  <= '0;
        end else begin
          if (wr_vec[c]) hold_q <= wdata;
          if (upd)       out_q  <= hold_q;
        end
      end
      assign first_flat[c*DATA_W +: DATA_W]  = hold_q;
      assign second_flat[c*DATA_W +: DATA_W] = out_q;
    end
  endgenerate
endmodule

// File: rtl/quad_dac_input_regs.sv
module quad_dac_input_regs
  import qdir_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int NUM_CH = 4,
  parameter int ADDR_W = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DATA_W-1:0]        din,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     sel_n,
  input  logic                     latch_n,
  input  logic                     mode_n,
  input  logic                     xfer_n,
  input  logic                     read_n,
  input  logic                     clear_n,
  output logic [NUM_CH*DATA_W-1:0] dout
);
  logic [NUM_STB-1:0]        raw_n, act;
  logic [DATA_W-1:0]         din_q1, din_q2;
  logic [ADDR_W-1:0]         addr_q1, addr_q2;
  logic [NUM_CH-1:0]         wr_vec;
  logic                      upd, clr;
  logic [NUM_CH*DATA_W-1:0]  first_flat;

  assign raw_n = {clear_n, read_n, xfer_n, mode_n, latch_n, sel_n};

  // data and address take the same two-stage delay as the strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q1  <= '0;
      din_q2  <= '0;
      addr_q1 <= '0;
      addr_q2 <= '0;
    end else begin
      din_q1  <= din;
      din_q2  <= din_q1;
      addr_q1 <= addr;
      addr_q2 <= addr_q1;
    end
  end

  qdir_strobe_sync #(.N(NUM_STB)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_n(raw_n), .act(act)
  );

  qdir_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .act(act), .addr_s(addr_q2),
    .wr_vec(wr_vec), .upd(upd), .clr(clr)
  );

  qdir_ranks #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_ranks (
    .clk(clk), .rst_n(rst_n), .clr(clr), .upd(upd), .wr_vec(wr_vec),
    .wdata(din_q2), .first_flat(first_flat), .second_flat(dout)
  );
endmodule

// File: rtl/qdir_checker.sv
module qdir_checker #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     clr,
  input logic                     upd,
  input logic                     read_act,
  input logic [NUM_CH-1:0]        wr_vec,
  input logic [NUM_CH*DATA_W-1:0] first_flat,
  input logic [NUM_CH*DATA_W-1:0] dout
);
  assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (dout == '0 && first_flat == '0));

  assert_single_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec));

  assert_hold_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !clr) |=> $stable(dout));

  assert_copy_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !clr) |=> (dout == $past(first_flat)));

  assert_first_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !clr) |=> $stable(first_flat));

  assert_read_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (read_act && !clr) |=> $stable(dout));
endmodule

bind quad_dac_input_regs qdir_checker #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .upd(upd),
  .read_act(act[qdir_pkg::STB_READ]), .wr_vec(wr_vec),
  .first_flat(first_flat), .dout(dout)
);

// File: tb/quad_dac_input_regs_bench.sv
`timescale 1ns/1ps
module quad_dac_input_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] din = '0;
  logic [1:0]  addr = '0;
  logic [5:0]  stb = 6'h3F;  // {clear,read,xfer,mode,latch,sel}, active low
  logic [47:0] dout;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  quad_dac_input_regs u_quad_dac_input_regs (
    .clk(clk), .rst_n(rst_n), .din(din), .addr(addr),
    .sel_n(stb[0]), .latch_n(stb[1]), .mode_n(stb[2]), .xfer_n(stb[3]),
    .read_n(stb[4]), .clear_n(stb[5]), .dout(dout)
  );

  // {req[71:68], strobes[67:62], addr[61:60], data[59:48], expected dout[47:0]}
  localparam logic [71:0] VEC [23] = '{
    {4'd2,  6'h3C, 2'd0, 12'h111, 48'h000_000_000_000}, // R2 write ch0
    {4'd3,  6'h3D, 2'd0, 12'h111, 48'h000_000_000_000}, // R3 select released first
    {4'd3,  6'h3F, 2'd0, 12'h000, 48'h000_000_000_000}, // R3
    {4'd5,  6'h3E, 2'd2, 12'h000, 48'h000_000_000_111}, // R5 bare update
    {4'd6,  6'h3F, 2'd0, 12'h000, 48'h000_000_000_111}, // R6
    {4'd2,  6'h3C, 2'd1, 12'h222, 48'h000_000_000_111}, // R2 write ch1
    {4'd4,  6'h3E, 2'd1, 12'h222, 48'h000_000_222_111}, // R4 latch released first
    {4'd6,  6'h3F, 2'd0, 12'h000, 48'h000_000_222_111}, // R6
    {4'd7,  6'h3C, 2'd2, 12'h333, 48'h000_000_222_111}, // R7 long select
    {4'd7,  6'h3E, 2'd2, 12'h333, 48'h000_333_222_111}, // R7
    {4'd7,  6'h3C, 2'd3, 12'h444, 48'h000_333_222_111}, // R7
    {4'd7,  6'h3E, 2'd3, 12'h444, 48'h444_333_222_111}, // R7
    {4'd7,  6'h3F, 2'd0, 12'h000, 48'h444_333_222_111}, // R7
    {4'd8,  6'h3C, 2'd0, 12'h0AA, 48'h444_333_222_111}, // R8 preload series
    {4'd8,  6'h3D, 2'd0, 12'h0AA, 48'h444_333_222_111}, // R8
    {4'd8,  6'h3F, 2'd0, 12'h000, 48'h444_333_222_111}, // R8
    {4'd8,  6'h3C, 2'd1, 12'h0BB, 48'h444_333_222_111}, // R8
    {4'd8,  6'h3D, 2'd1, 12'h0BB, 48'h444_333_222_111}, // R8
    {4'd8,  6'h3F, 2'd0, 12'h000, 48'h444_333_222_111}, // R8
    {4'd5,  6'h3E, 2'd3, 12'h000, 48'h444_333_0BB_0AA}, // R5 address ignored
    {4'd6,  6'h3F, 2'd0, 12'h000, 48'h444_333_0BB_0AA}, // R6
    {4'd6,  6'h3E, 2'd0, 12'h000, 48'h444_333_0BB_0AA}, // R6 repeat update
    {4'd6,  6'h3F, 2'd0, 12'h000, 48'h444_333_0BB_0AA}  // R6
  };

  task automatic check(input int req, input logic [47:0] exp);
    checks++;
    if (dout !== exp) begin
      fails++;
      $display("FAIL R%0d dout=%h expected=%h", req, dout, exp);
    end
  endtask

  task automatic drive(input logic [5:0] s, input logic [1:0] a, input logic [11:0] d);
    @(negedge clk);
    stb = s; addr = a; din = d;
  endtask

  task automatic step(input int req, input logic [5:0] s, input logic [1:0] a,
                      input logic [11:0] d, input logic [47:0] exp);
    drive(s, a, d);
    repeat (4) @(posedge clk);
    #1 check(req, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check(1, 48'h0);  // R1 reset state
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(posedge clk);

    for (int i = 0; i < 23; i++)
      step(int'(VEC[i][71:68]), VEC[i][67:62], VEC[i][61:60], VEC[i][59:48], VEC[i][47:0]);

    // R9: preload ch3, then a select pulse with read low must not copy
    step(9, 6'h3C, 2'd3, 12'h555, 48'h444_333_0BB_0AA);
    step(9, 6'h3D, 2'd3, 12'h555, 48'h444_333_0BB_0AA);
    step(9, 6'h3F, 2'd0, 12'h000, 48'h444_333_0BB_0AA);
    step(9, 6'h2E, 2'd0, 12'h000, 48'h444_333_0BB_0AA);
    step(9, 6'h3F, 2'd0, 12'h000, 48'h444_333_0BB_0AA);
    // R10: mode or transfer low blocks the copy
    step(10, 6'h36, 2'd0, 12'h000, 48'h444_333_0BB_0AA);
    step(10, 6'h3F, 2'd0, 12'h000, 48'h444_333_0BB_0AA);
    step(10, 6'h3A, 2'd0, 12'h000, 48'h444_333_0BB_0AA);
    step(10, 6'h3F, 2'd0, 12'h000, 48'h444_333_0BB_0AA);
    // R11: output moves on the third edge, not the second; read did not lose ch3
    drive(6'h3E, 2'd0, 12'h000);
    repeat (2) @(posedge clk);
    #1 check(11, 48'h444_333_0BB_0AA);
    @(posedge clk);
    #1 check(11, 48'h555_333_0BB_0AA);
    step(11, 6'h3F, 2'd0, 12'h000, 48'h555_333_0BB_0AA);
    // R1: clear wins over a simultaneous write, and both stages are emptied
    step(1, 6'h1C, 2'd0, 12'hFFF, 48'h0);
    step(1, 6'h3F, 2'd0, 12'h000, 48'h0);
    step(1, 6'h3E, 2'd0, 12'h000, 48'h0);
    step(1, 6'h3F, 2'd0, 12'h000, 48'h0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule